// File: doc/BRIEF.md
# Program Memory Table Access Unit

This unit lets a 16-bit data path use a 24-bit-wide program memory as ordinary data storage. Each program word spans two address units. The word therefore looks like two 16-bit spaces that share one address range. The low space holds program bits 15:0. The high space holds program bits 23:16 in its lower byte, and its upper byte is a "phantom" byte that always reads as zero.

An 8-bit page register, loaded through its own strobe, supplies the upper part of the memory address. A command gives an effective address, a byte/word flag and, for writes, write data. The unit builds the word address from these and drives a synchronous memory port with one write enable per byte. It returns read data one cycle later, with the selected lane moved to the low bits and the rest filled with zeros.

When the top bit of the page register is set, accesses go to configuration space. Writes are blocked there and reported through an error flag. Writes aimed at the phantom byte are dropped without any error.

Top module: `prog_table_port`

## Requirements
- R1: The memory word address `mem_addr` equals the page register concatenated above `cmd_ea[15:1]`. It is presented combinationally in the command cycle, and `mem_en` follows `cmd_valid`. `cmd_op` encodes read-low as 0, read-high as 1, write-low as 2 and write-high as 3.
- R2: A word read-low (`cmd_byte`=0) returns program bits 15:0 unchanged on `rd_data`.
- R3: A byte read-low returns program bits 7:0 when `cmd_ea[0]`=0 and bits 15:8 when it is 1. The byte is placed in `rd_data[7:0]`, and `rd_data[15:8]` is zero.
- R4: A word read-high returns program bits 23:16 in `rd_data[7:0]`, and `rd_data[15:8]` is always zero.
- R5: A byte read-high returns program bits 23:16 in `rd_data[7:0]` when `cmd_ea[0]`=0. When `cmd_ea[0]`=1 it returns all zeros.
- R6: `cfg_space` equals bit 7 of the page register.
- R7: In user space, a word write-low sets `mem_we`=3'b011 with `mem_wdata[15:0]`=`cmd_wdata`. A byte write-low sets `mem_we`=3'b001 and places `cmd_wdata[7:0]` in `mem_wdata[7:0]` when `cmd_ea[0]`=0. When `cmd_ea[0]`=1 it sets `mem_we`=3'b010 and places `cmd_wdata[7:0]` in `mem_wdata[15:8]`. Bit k of `mem_we` enables program bits 8k+7:8k.
- R8: In user space, a write-high in word mode, or in byte mode with `cmd_ea[0]`=0, sets `mem_we`=3'b100 with `mem_wdata[23:16]`=`cmd_wdata[7:0]`. `cmd_wdata[15:8]` is discarded. A byte write-high with `cmd_ea[0]`=1 targets the phantom byte and leaves `mem_we` at zero.
- R9: A write issued while page bit 7 is set drives `mem_we` to zero. It also raises `wr_err` for exactly the one cycle after the command.
- R10: The page register resets to zero. `page_we` loads it from `page_wdata`, and the new value takes effect from the next cycle.
- R11: `rd_valid` is high exactly in the cycle after a read command, and `rd_data` is zero whenever `rd_valid` is low. A new command is accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page_we | input | 1 | Page register load strobe |
| page_wdata | input | 8 | New page value |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 read-low, 1 read-high, 2 write-low, 3 write-high |
| cmd_byte | input | 1 | 1 selects byte mode |
| cmd_ea | input | 16 | Effective address |
| cmd_wdata | input | 16 | Write data |
| mem_en | output | 1 | Memory access enable |
| mem_addr | output | 23 | Program word address |
| mem_we | output | 3 | Per-byte write enables |
| mem_wdata | output | 24 | Memory write data |
| mem_rdata | input | 24 | Memory read data, one cycle after `mem_en` |
| rd_data | output | 16 | Formatted read data |
| rd_valid | output | 1 | Read data valid |
| cfg_space | output | 1 | Configuration space selected |
| wr_err | output | 1 | Rejected configuration-space write |

## Verification
The address, write enables, write data and space flag depend only on the command and the current page, with no register in between. The bench therefore samples them 1 ns after it drives a command, on the falling edge. Read data, read-valid and the write error each pass through one register, so they are due on the falling edge that follows the next rising edge. The bench holds its expected values for one cycle and compares them there, before it drives the next command. Page loads are checked through the address of the first command after the load edge. Writes are checked by reading the same word back from a bench memory model that the unit updated.

// File: rtl/prog_table_port.sv
module prog_table_port #(
  parameter int PAGE_W = 8,
  parameter int EA_W   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    page_we,
  input  logic [PAGE_W-1:0]       page_wdata,
  input  logic                    cmd_valid,
  input  logic [1:0]              cmd_op,
  input  logic                    cmd_byte,
  input  logic [EA_W-1:0]         cmd_ea,
  input  logic [15:0]             cmd_wdata,
  output logic                    mem_en,
  output logic [PAGE_W+EA_W-2:0]  mem_addr,
  output logic [2:0]              mem_we,
  output logic [23:0]             mem_wdata,
  input  logic [23:0]             mem_rdata,
  output logic [15:0]             rd_data,
  output logic                    rd_valid,
  output logic                    cfg_space,
  output logic                    wr_err
);
  logic [PAGE_W-1:0] page_r;
  logic [2:0]        we_raw;
  logic              rd_hi_q, rd_byte_q, rd_lane_q;

  wire is_wr = cmd_op[1];
  wire is_hi = cmd_op[0];
  wire lane  = cmd_ea[0];

  always_ff @(posedge clk) begin
    if (!rst_n)       page_r <= '0;
    else if (page_we) page_r <= page_wdata;
  end

  assign cfg_space = page_r[PAGE_W-1];
  assign mem_en    = cmd_valid;
  assign mem_addr  = {page_r, cmd_ea[EA_W-1:1]};

  always_comb begin
    we_raw    = 3'b000;
    mem_wdata = '0;
    if (!is_hi) begin
      if (!cmd_byte) begin
        we_raw          = 3'b011;
        mem_wdata[15:0] = cmd_wdata;
      end else if (!lane) begin
        we_raw          = 3'b001;
        mem_wdata[7:0]  = cmd_wdata[7:0];
      end else begin
        we_raw          = 3'b010;
        mem_wdata[15:8] = cmd_wdata[7:0];
      end
    end else if (!(cmd_byte && lane)) begin
      we_raw           = 3'b100;
      mem_wdata[23:16] = cmd_wdata[7:0];
    end
  end

  assign mem_we = (cmd_valid && is_wr && !cfg_space) ? we_raw : 3'b000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      wr_err    <= 1'b0;
      rd_hi_q   <= 1'b0;
      rd_byte_q <= 1'b0;
      rd_lane_q <= 1'b0;
    end else begin
      rd_valid  <= cmd_valid && !is_wr;
      wr_err    <= cmd_valid && is_wr && cfg_space;
      rd_hi_q   <= is_hi;
      rd_byte_q <= cmd_byte;
      rd_lane_q <= lane;
    end
  end

  always_comb begin
    rd_data = 16'h0000;
    if (rd_valid) begin
      if (!rd_hi_q) begin
        if (!rd_byte_q)     rd_data = mem_rdata[15:0];
        else if (rd_lane_q) rd_data = {8'h00, mem_rdata[15:8]};
        else                rd_data = {8'h00, mem_rdata[7:0]};
      end else if (!(rd_byte_q && rd_lane_q)) begin
        rd_data = {8'h00, mem_rdata[23:16]};
      end
    end
  end

  AST_CFG_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op[1] && cfg_space |-> mem_we == 3'b000); // R9
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op[1] && cfg_space |=> wr_err); // R9
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_op[1] && cfg_space) |=> !wr_err); // R9
  AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_op[1] |=> rd_valid); // R11
  AST_READ_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_op[1]) |-> mem_we == 3'b000); // R11
  AST_PHANTOM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && $past(cmd_op[0]) |-> rd_data[15:8] == 8'h00); // R4
  AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    page_we |=> page_r == $past(page_wdata)); // R10
  AST_IDLE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == 16'h0000); // R11
endmodule

// File: tb/prog_table_port_bench.sv
module prog_table_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        page_we = 1'b0;
  logic [7:0]  page_wdata = '0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic        cmd_byte = 1'b0;
  logic [15:0] cmd_ea = '0;
  logic [15:0] cmd_wdata = '0;
  logic        mem_en;
  logic [22:0] mem_addr;
  logic [2:0]  mem_we;
  logic [23:0] mem_wdata;
  logic [23:0] mem_rdata = '0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        cfg_space;
  logic        wr_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  prog_table_port u_prog_table_port (.*);

  logic [23:0] dut_mem [int];
  logic [23:0] exp_mem [int];

  always @(posedge clk) begin
    if (mem_en) begin
      mem_rdata <= dut_mem.exists(int'(mem_addr)) ? dut_mem[int'(mem_addr)] : 24'h0;
      for (int k = 0; k < 3; k++)
        if (mem_we[k]) begin
          if (!dut_mem.exists(int'(mem_addr))) dut_mem[int'(mem_addr)] = 24'h0;
          dut_mem[int'(mem_addr)][8*k +: 8] = mem_wdata[8*k +: 8];
        end
    end
  end

  logic [7:0]  m_page = 8'h00;
  logic        p_rv = 0, p_err = 0;
  logic [15:0] p_rd = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] rdw(input int a);
    return exp_mem.exists(a) ? exp_mem[a] : 24'h0;
  endfunction

  function automatic logic [15:0] fmt_read(input logic [23:0] w, input logic hi, input logic by, input logic ln);
    if (!hi) return by ? {8'h00, (ln ? w[15:8] : w[7:0])} : w[15:0];
    return (by && ln) ? 16'h0000 : {8'h00, w[23:16]};
  endfunction

  task automatic step(input logic v, input logic [1:0] op, input logic by,
                      input logic [15:0] ea, input logic [15:0] wd,
                      input logic pw, input logic [7:0] pd);
    logic [2:0]  ewe;
    logic [23:0] ewd;
    int a;
    @(negedge clk);
    chk("R11", "rd_valid", rd_valid, p_rv);
    chk(p_rv ? "R2 R3 R4 R5" : "R11", "rd_data", rd_data, p_rd);
    chk("R9", "wr_err", wr_err, p_err);
    cmd_valid = v; cmd_op = op; cmd_byte = by; cmd_ea = ea; cmd_wdata = wd;
    page_we = pw; page_wdata = pd;
    #1;
    a = int'({m_page, ea[15:1]});
    chk("R6", "cfg_space", cfg_space, m_page[7]);
    chk("R1", "mem_en", mem_en, v);
    if (v) chk("R1 R10", "mem_addr", mem_addr, a);
    ewe = 3'b000; ewd = 24'h0;
    if (v && op[1] && !m_page[7]) begin
      if (!op[0]) begin
        if (!by)        begin ewe = 3'b011; ewd[15:0] = wd; end
        else if (!ea[0]) begin ewe = 3'b001; ewd[7:0] = wd[7:0]; end
        else            begin ewe = 3'b010; ewd[15:8] = wd[7:0]; end
      end else if (!(by && ea[0])) begin
        ewe = 3'b100; ewd[23:16] = wd[7:0];
      end
    end
    chk(op[0] ? "R8 R9" : "R7 R9", "mem_we", mem_we, ewe);
    for (int k = 0; k < 3; k++)
      if (ewe[k]) chk(op[0] ? "R8" : "R7", "mem_wdata lane", mem_wdata[8*k +: 8], ewd[8*k +: 8]);
    p_rv  = v && !op[1];
    p_rd  = p_rv ? fmt_read(rdw(a), op[0], by, ea[0]) : 16'h0;
    p_err = v && op[1] && m_page[7];
    if (ewe != 0) begin
      logic [23:0] w;
      w = rdw(a);
      for (int k = 0; k < 3; k++) if (ewe[k]) w[8*k +: 8] = ewd[8*k +: 8];
      exp_mem[a] = w;
    end
    if (pw) m_page = pd;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "reset rd_valid", rd_valid, 0);
    chk("R10", "reset wr_err", wr_err, 0);
    chk("R6 R10", "reset cfg_space", cfg_space, 0);
    chk("R10", "reset mem_we", mem_we, 0);
    // directed: word write, then each read form of that word
    step(1, 2'd2, 0, 16'h0010, 16'hBEEF, 0, 0);
    step(1, 2'd3, 0, 16'h0010, 16'hA55C, 0, 0);   // R8 upper data byte dropped
    step(1, 2'd0, 0, 16'h0010, 0, 0, 0);          // R2
    step(1, 2'd0, 1, 16'h0010, 0, 0, 0);          // R3 lane 0
    step(1, 2'd0, 1, 16'h0011, 0, 0, 0);          // R3 lane 1
    step(1, 2'd1, 0, 16'h0010, 0, 0, 0);          // R4
    step(1, 2'd1, 1, 16'h0010, 0, 0, 0);          // R5 lane 0
    step(1, 2'd1, 1, 16'h0011, 0, 0, 0);          // R5 phantom
    step(1, 2'd3, 1, 16'h0011, 16'h0077, 0, 0);   // R8 phantom write ignored
    step(1, 2'd1, 0, 16'h0010, 0, 0, 0);
    step(1, 2'd2, 1, 16'h0011, 16'h0012, 0, 0);   // R7 byte lane 1
    step(1, 2'd0, 0, 16'h0010, 0, 1, 8'h80);      // R10 load cfg page
    step(1, 2'd2, 0, 16'h0010, 16'h1234, 0, 0);   // R9 blocked
    step(1, 2'd0, 0, 16'h0010, 0, 1, 8'h00);
    step(1, 2'd0, 0, 16'h0010, 0, 0, 0);          // R9 memory unchanged
    step(0, 2'd0, 0, 0, 0, 0, 0);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] pg;
      logic pw;
      pw = ($urandom % 16) == 0;
      case ($urandom % 4)
        0: pg = 8'h00; 1: pg = 8'h01; 2: pg = 8'h80; default: pg = 8'h81;
      endcase
      step(($urandom % 8) != 0, 2'($urandom), 1'($urandom), 16'($urandom % 32),
           16'($urandom), pw, pg);
    end
    step(0, 2'd0, 0, 0, 0, 0, 0);
    step(0, 2'd0, 0, 0, 0, 0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule